// File: doc/BRIEF.md
# Deserializer Word Alignment Synchronizer

This block brings the parallel words of a serial-to-parallel converter into a known bit order before a self-test comparison starts. While a training pattern is streamed, the block watches one chosen bit of each deserialized word. The surrounding logic selects that bit and presents it on `sample_bit`. When the bit does not hold the expected training value, the block sends a single-cycle slip request back to the deserializer. Each request rotates the word ordering by one position. The block then waits until the reordered data has settled before it decides again.

The block runs in the divided (word-rate) clock domain. Its pacing comes from a three-flop one-hot phase ring, which opens a decision point on every third enabled edge. The pattern generator drives `sync_en` to turn the circuit on or off. The synchronous `clr` returns the block to its initial state. Alignment is declared after two consecutive matching decisions. After that, and likewise after a give-up, the block stays quiet until the next clear. If `2*DATA_W` slips have not produced alignment, the block raises a failure flag instead of slipping again.

Top module: `bsync_aligner`

## Requirements
- R1: After reset, `bitslip`, `aligned` and `align_fail` are 0. The phase ring is loaded so that the first edge with `sync_en` high is a decision point.
- R2: While `sync_en` is low, the phase ring holds, no decision is taken and `bitslip` stays 0. An enable delay of D edges therefore postpones every later event by exactly D edges.
- R3: When `sample_bit` differs from `EXP_BIT` (default 1) at a decision edge, `bitslip` is 1 for exactly one cycle, starting right after that edge. The bench takes `sample_bit` from bit 1 of the rotated training word.
- R4: Decision points fall on every third enabled edge. Two `bitslip` pulses are therefore at least three cycles apart, except across a clear.
- R5: `aligned` rises right after the second consecutive matching decision. A mismatch restarts that run. From reset with k slips needed and `sync_en` high, `aligned` is first seen after edge 4+3k.
- R6: Once `aligned` is 1, it stays 1 and no `bitslip` is issued until a clear.
- R7: If a mismatching decision arrives after `2*DATA_W` slips have been issued, `align_fail` rises instead of another pulse. The flag is sticky, and it is never high together with `aligned`.
- R8: `clr` high at an edge restores the R1 state on that edge, whatever `sync_en` is, and clears both sticky flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_div | input | 1 | Divided word-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear, has priority over enable |
| sync_en | input | 1 | Synchronizer enable from the pattern generator |
| sample_bit | input | 1 | Observed bit of the deserialized word |
| bitslip | output | 1 | One-cycle request to rotate the deserializer ordering |
| aligned | output | 1 | Sticky alignment-reached flag |
| align_fail | output | 1 | Sticky alignment-failure flag |

## Verification
The bench counts rising edges from reset release. It checks outputs at the falling edge after each rising edge. A slip pulse is due in the cycle after the decision edge where the mismatch was seen. `aligned` is due after edge 4+3k. With k = 0 that is edge 4, the second decision point, since the first decision point is edge 1. `align_fail` is due after edge 1+3·2·DATA_W. An enable delay of D shifts every one of these by D edges. A model of the deserializer rotates the training word at each observed pulse, so the expected edge numbers follow from simple arithmetic on the training bit position. All of them are compared exactly.

// File: rtl/bsync_pkg.sv
package bsync_pkg;

    // One-hot phase ring: z marks a decision point, x and y are the settle slots
    typedef struct packed {
        logic x;
        logic y;
        logic z;
    } ring_t;

    localparam ring_t RING_INIT = '{x: 1'b0, y: 1'b0, z: 1'b1};

endpackage

// File: rtl/bsync_phase_ring.sv
module bsync_phase_ring
    import bsync_pkg::*;
(
    input  logic clk_div,
    input  logic rst_n,
    input  logic clr,
    input  logic sync_en,
    output logic decide
);

    ring_t ring_d, ring_q;

    always_comb begin
        ring_d = ring_q;
        if (clr) begin
            ring_d = RING_INIT;
        end else if (sync_en) begin
            ring_d.x = ring_q.z;
            ring_d.y = ring_q.x;
            ring_d.z = ring_q.y;
        end
    end

    always_ff @(posedge clk_div or negedge rst_n) begin
        if (!rst_n) ring_q <= RING_INIT;
        else        ring_q <= ring_d;
    end

    assign decide = sync_en && ring_q.z && !clr;

    AST_RING_ONE_PHASE: assert property (@(posedge clk_div) disable iff (!rst_n)
        $countones({ring_q.x, ring_q.y, ring_q.z}) == 1); // R4
    AST_RING_FROZEN: assert property (@(posedge clk_div) disable iff (!rst_n)
        (!sync_en && !clr) |=> $stable(ring_q)); // R2

endmodule

// File: rtl/bsync_decider.sv
module bsync_decider #(
    parameter int DATA_W = 6
) (
    input  logic clk_div,
    input  logic rst_n,
    input  logic clr,
    input  logic decide,
    input  logic hit,
    output logic bitslip,
    output logic aligned,
    output logic align_fail
);

    localparam int MAX_SLIPS = 2 * DATA_W;
    localparam int AW        = $clog2(MAX_SLIPS + 1);

    typedef struct packed {
        logic          run;
        logic [AW-1:0] tries;
        logic          lock;
        logic          fail;
        logic          slip;
    } dec_t;

    localparam dec_t DEC_INIT = '{run: 1'b0, tries: '0, lock: 1'b0, fail: 1'b0, slip: 1'b0};

    dec_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.slip = 1'b0;
        if (clr) begin
            st_d = DEC_INIT;
        end else if (decide && !st_q.lock && !st_q.fail) begin
            if (hit) begin
                if (st_q.run) st_d.lock = 1'b1;
                st_d.run = 1'b1;
            end else begin
                st_d.run = 1'b0;
                if (st_q.tries == AW'(MAX_SLIPS)) begin
                    st_d.fail = 1'b1;
                end else begin
                    st_d.slip  = 1'b1;
                    st_d.tries = st_q.tries + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_div or negedge rst_n) begin
        if (!rst_n) st_q <= DEC_INIT;
        else        st_q <= st_d;
    end

    assign bitslip    = st_q.slip;
    assign aligned    = st_q.lock;
    assign align_fail = st_q.fail;

    AST_PULSE_SINGLE: assert property (@(posedge clk_div) disable iff (!rst_n)
        bitslip |=> !bitslip); // R3
    AST_SLIP_GAP: assert property (@(posedge clk_div) disable iff (!rst_n || clr)
        bitslip |=> !bitslip ##1 !bitslip); // R4
    AST_LOCK_QUIET: assert property (@(posedge clk_div) disable iff (!rst_n)
        aligned |-> !bitslip); // R6
    AST_LOCK_STICKY: assert property (@(posedge clk_div) disable iff (!rst_n)
        (aligned && !clr) |=> aligned); // R6
    AST_FAIL_STICKY: assert property (@(posedge clk_div) disable iff (!rst_n)
        (align_fail && !clr) |=> align_fail && !bitslip); // R7
    AST_FLAGS_EXCL: assert property (@(posedge clk_div) disable iff (!rst_n)
        !(aligned && align_fail)); // R7
    AST_CLEAR_STATE: assert property (@(posedge clk_div) disable iff (!rst_n)
        clr |=> !bitslip && !aligned && !align_fail); // R8

endmodule

// File: rtl/bsync_aligner.sv
module bsync_aligner #(
    parameter int   DATA_W  = 6,
    parameter logic EXP_BIT = 1'b1
) (
    input  logic clk_div,
    input  logic rst_n,
    input  logic clr,
    input  logic sync_en,
    input  logic sample_bit,
    output logic bitslip,
    output logic aligned,
    output logic align_fail
);

    logic decide;
    logic hit;

    assign hit = (sample_bit == EXP_BIT);

    bsync_phase_ring u_ring (
        .clk_div (clk_div),
        .rst_n   (rst_n),
        .clr     (clr),
        .sync_en (sync_en),
        .decide  (decide)
    );

    bsync_decider #(.DATA_W(DATA_W)) u_dec (
        .clk_div    (clk_div),
        .rst_n      (rst_n),
        .clr        (clr),
        .decide     (decide),
        .hit        (hit),
        .bitslip    (bitslip),
        .aligned    (aligned),
        .align_fail (align_fail)
    );

    AST_SLIP_NEEDS_EN: assert property (@(posedge clk_div) disable iff (!rst_n)
        bitslip |-> $past(sync_en)); // R2
    AST_SLIP_ON_MISS: assert property (@(posedge clk_div) disable iff (!rst_n)
        bitslip |-> $past(sample_bit) != EXP_BIT); // R3

endmodule

// File: tb/tb_bsync_aligner.sv
module tb_bsync_aligner;

    localparam int W   = 6;
    localparam int OBS = 1;
    localparam int MAXS = 2 * W;

    logic clk = 1'b0;
    logic rst_n, clr, sync_en, sample_bit;
    logic bitslip, aligned, align_fail;

    always #4 clk = ~clk;

    bsync_aligner #(.DATA_W(W), .EXP_BIT(1'b1)) dut (
        .clk_div(clk), .rst_n(rst_n), .clr(clr), .sync_en(sync_en),
        .sample_bit(sample_bit), .bitslip(bitslip), .aligned(aligned),
        .align_fail(align_fail)
    );

    int n_chk = 0, n_bad = 0;
    int edge_n, slips, last_slip, first_slip, align_edge, fail_edge, rot, en_dly;
    logic [W-1:0] train, man_word, word;
    logic manual, prev_slip;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] rotl(input logic [W-1:0] v, input int r);
        logic [W-1:0] o;
        for (int i = 0; i < W; i++) o[(i + r) % W] = v[i];
        return o;
    endfunction

    task automatic drive();
        word       = manual ? man_word : rotl(train, rot);
        sample_bit = word[OBS];
        sync_en    = (edge_n >= en_dly);
    endtask

    task automatic step();
        @(posedge clk);
        edge_n++;
        @(negedge clk);
        if (bitslip) begin
            chk(!prev_slip && (last_slip < 0 || edge_n - last_slip >= 3),
                "R3/R4 pulse width or spacing", edge_n, last_slip + 3);
            if (first_slip < 0) first_slip = edge_n;
            slips++;
            last_slip = edge_n;
            rot = (rot + 1) % W;
        end
        prev_slip = bitslip;
        if (aligned && align_edge < 0) align_edge = edge_n;
        if (align_fail && fail_edge < 0) fail_edge = edge_n;
        drive();
    endtask

    task automatic clear_marks();
        slips = 0; last_slip = -1; first_slip = -1;
        align_edge = -1; fail_edge = -1; prev_slip = 1'b0;
    endtask

    task automatic do_reset(input logic [W-1:0] t, input int dly);
        rst_n = 1'b0; clr = 1'b0; manual = 1'b0;
        train = t; man_word = '0; rot = 0; en_dly = dly; edge_n = 0;
        clear_marks();
        drive();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset(6'b000010, 0);
        chk(!bitslip && !aligned && !align_fail, "R1 reset outputs", {bitslip, aligned, align_fail}, 0);

        // R3/R5/R6/R7: sweep training bit position
        for (int p = 0; p < W; p++) begin
            int k;
            k = (1 - p + 2 * W) % W;
            do_reset(W'(1) << p, 0);
            repeat (4 + 3 * k + 20) step();
            chk(slips == k, "R3 slip count", slips, k);
            chk(align_edge == 4 + 3 * k, "R5 align edge", align_edge, 4 + 3 * k);
            chk(last_slip < align_edge, "R6 no slip after lock", last_slip, align_edge - 1);
            chk(fail_edge < 0 && aligned, "R7 no fail when aligned", fail_edge, -1);
        end

        // R2: enable held low delays everything
        begin
            int d, k;
            d = 5; k = 3;
            do_reset(6'b010000, d);
            repeat (d) step();
            chk(slips == 0 && !aligned, "R2 quiet while disabled", slips, 0);
            repeat (4 + 3 * k + 10) step();
            chk(first_slip == d + 1, "R2 first slip edge", first_slip, d + 1);
            chk(align_edge == 4 + 3 * k + d, "R2 align edge shifted", align_edge, 4 + 3 * k + d);
        end

        // R7: no alignment possible
        do_reset(6'b000000, 0);
        repeat (50) step();
        chk(slips == MAXS, "R7 slip limit", slips, MAXS);
        chk(fail_edge == 1 + 3 * MAXS, "R7 fail edge", fail_edge, 1 + 3 * MAXS);
        chk(!aligned && align_fail, "R7 flags", {aligned, align_fail}, 1);
        chk(last_slip == 1 + 3 * (MAXS - 1), "R7 last slip", last_slip, 1 + 3 * (MAXS - 1));

        // R8: clear after failure, then realign with a usable pattern
        begin
            int c;
            train = 6'b000010; rot = 0; drive();
            clr = 1'b1;
            step();
            clr = 1'b0;
            c = edge_n;
            chk(!bitslip && !aligned && !align_fail, "R8 clear outputs", {bitslip, aligned, align_fail}, 0);
            clear_marks();
            repeat (8) step();
            chk(align_edge == c + 4, "R8 realign after clear", align_edge, c + 4);
        end

        // R8: clear after lock, with enable low at the clear edge
        begin
            int c;
            en_dly = 0;
            sync_en = 1'b0; clr = 1'b1;
            @(posedge clk); edge_n++; @(negedge clk);
            clr = 1'b0;
            c = edge_n;
            chk(!aligned && !bitslip, "R8 clear beats enable", aligned, 0);
            clear_marks();
            drive();
            repeat (6) step();
            chk(align_edge == c + 4, "R8 lock after clear", align_edge, c + 4);
        end

        // R5: match, mismatch, match, match
        do_reset(6'b000000, 0);
        manual = 1'b1; man_word = 6'b000010; drive();
        step();                          // edge 1 match
        step(); step();
        man_word = 6'b000000; drive();
        step();                          // edge 4 mismatch
        chk(bitslip == 1'b1, "R3 slip after mismatch", bitslip, 1);
        step(); step();
        man_word = 6'b000010; drive();
        step();                          // edge 7 match
        chk(!aligned, "R5 run restarted by mismatch", aligned, 0);
        step(); step(); step();          // edge 10 match
        chk(aligned && align_edge == 10, "R5 lock after two matches", align_edge, 10);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule